// File: doc/BRIEF.md
# Multichannel Pulse-Stretch Interrupt Front-End

This block sits between a set of remote event sensors and a host that reads an 8-bit parallel input word and services a single interrupt line. Each sensor input is brought into the clock domain, masked by a per-channel enable and edge-detected. A rising edge starts a retriggerable one-shot that holds that channel's data bit high for a fixed number of clocks. The pulse is long enough that a slow host still finds the bit set when its interrupt handler reads the word.

The interrupt line is a registered OR of all stretched bits, so it rises one clock after the data word. The data lines are therefore settled before a fast host reacts to the interrupt. A separate call request from the host produces an interrupt pulse of the same length without setting any data bit. The host uses this to find out which interrupt line the block is wired to, and to check that a sensor front-end is present.

A broken or floating input cannot cause an interrupt storm. A disabled channel is forced to zero before edge detection. An input that toggles faster than the pulse length keeps retriggering its one-shot, so the interrupt line stays high as one level instead of toggling.

Top module: `pulse_irq_frontend`

## Requirements
- R1: With its enable bit at 1, a rising edge on an event input sets the matching `data_word` bit after the third rising clock edge, counting the edge that first samples the new level. It is not set after the first or second of those edges.
- R2: After a single rising edge, the `data_word` bit stays high for exactly `PULSE_CYCLES` clock cycles.
- R3: A new rising edge while a channel's pulse is active reloads its count. Two rising edges whose loads are k cycles apart (k < `PULSE_CYCLES`) give a high time of k + `PULSE_CYCLES` cycles.
- R4: `irq` is registered. In each cycle it equals the OR of all `data_word` bits and the call pulse from the previous cycle, so it rises exactly one clock after the data bit.
- R5: A rising edge on `call_req` (synchronized like the event inputs) drives `irq` high for exactly `PULSE_CYCLES` cycles and sets no `data_word` bit. Holding `call_req` high gives only one pulse.
- R6: A channel whose `ch_enable` bit is 0 never sets its `data_word` bit or `irq`, whatever its input does.
- R7: An input that toggles with a rise period shorter than `PULSE_CYCLES` keeps `irq` continuously high, with no falling edge, for as long as the toggling lasts.
- R8: While `rst` (synchronous, active high) is sampled high, all counters and synchronizers clear, and `data_word` and `irq` read 0 after that edge.
- R9: An input held high produces a single pulse. It gives no further pulse until the input falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_in | input | NUM_CH | Asynchronous active-high event inputs, one per channel |
| ch_enable | input | NUM_CH | Per-channel enable; 0 forces the channel to idle |
| call_req | input | 1 | Host call request (level); a rising edge requests an acknowledge pulse |
| data_word | output | NUM_CH | Stretched event levels, bit i for channel i |
| irq | output | 1 | Active-high interrupt request |

## Verification
The hardest situation to reach from the ports is a retrigger that arrives while a pulse is still running, especially near its end, combined with an overlapping call pulse on the interrupt line. Uniform random inputs either hold levels or toggle every cycle, and both miss that window. The random phase therefore flips each input bit with a probability of about one in eight per cycle, and toggles the call request about once every 32 cycles. Re-rises then land at many points inside the pulse window, and call pulses overlap channel pulses. A bench model built on a recorded history of the driven inputs predicts every data bit and the interrupt in every cycle. Directed sequences pin down the exact latency, the extended length after a retrigger, and the storm case of fast toggling.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  // Next value of a retriggerable down-counter: a load restores the full
  // length, otherwise count down to zero and stay there.
  function automatic int unsigned stretch_next(int unsigned cur, logic load,
                                               int unsigned len);
    if (load) return len;
    if (cur != 0) return cur - 1;
    return 0;
  endfunction

  // Rising-edge detect on a single level against its previous sample.
  function automatic logic rise_of(logic now_lvl, logic prev_lvl);
    return now_lvl & ~prev_lvl;
  endfunction

endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
  parameter int unsigned WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= d_i;
      stable_q <= meta_q;
    end
  end

  assign q_o = stable_q;

endmodule

// File: rtl/pirq_oneshot.sv
module pirq_oneshot
  import pirq_pkg::*;
#(
  parameter int unsigned LEN   = 16,
  parameter int unsigned CNT_W = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic load_o,
  output logic active_o
);

  logic             prev_q;
  logic [CNT_W-1:0] cnt_q;

  assign load_o = rise_of(level_i, prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= level_i;
      cnt_q  <= CNT_W'(stretch_next(32'(cnt_q), load_o, LEN));
    end
  end

  assign active_o = (cnt_q != '0);

endmodule

// File: rtl/pulse_irq_frontend.sv
module pulse_irq_frontend #(
  parameter int unsigned NUM_CH       = 8,
  parameter int unsigned PULSE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ev_in,
  input  logic [NUM_CH-1:0] ch_enable,
  input  logic              call_req,
  output logic [NUM_CH-1:0] data_word,
  output logic              irq
);

  localparam int unsigned SYNC_W  = NUM_CH + 1;
  localparam int unsigned CALL_IX = NUM_CH;
  localparam int unsigned CNT_W   = $clog2(PULSE_CYCLES + 1);

  logic [SYNC_W-1:0] sync_w;
  logic [NUM_CH-1:0] gated_w;
  logic [NUM_CH-1:0] ch_load;   // per-channel one-shot (re)load events
  logic [NUM_CH-1:0] stretched_w;
  logic              call_load; // call one-shot load event
  logic              call_active;
  logic              irq_q;

  pirq_sync #(.WIDTH(SYNC_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({call_req, ev_in}),
    .q_o (sync_w)
  );

  // Mask after synchronization so a disabled line never reaches an edge detector.
  assign gated_w = sync_w[NUM_CH-1:0] & ch_enable;

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    pirq_oneshot #(.LEN(PULSE_CYCLES), .CNT_W(CNT_W)) u_os (
      .clk      (clk),
      .rst      (rst),
      .level_i  (gated_w[gi]),
      .load_o   (ch_load[gi]),
      .active_o (stretched_w[gi])
    );
  end

  pirq_oneshot #(.LEN(PULSE_CYCLES), .CNT_W(CNT_W)) u_call (
    .clk      (clk),
    .rst      (rst),
    .level_i  (sync_w[CALL_IX]),
    .load_o   (call_load),
    .active_o (call_active)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (|stretched_w) | call_active;
  end

  assign data_word = stretched_w;
  assign irq       = irq_q;

endmodule

// File: rtl/pirq_checker.sv
module pirq_checker #(
  parameter int unsigned NUM_CH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] data_word,
  input logic              irq,
  input logic [NUM_CH-1:0] ch_load,
  input logic              call_load
);

  // R1: a load sets every loaded channel's bit on the next edge
  p_load_sets_bit_r1: assert property (@(posedge clk) disable iff (rst)
    (ch_load != '0) |=> ((data_word & $past(ch_load)) == $past(ch_load)));

  // R2: a data bit can only rise because of a load in the cycle before
  p_rise_from_load_r2: assert property (@(posedge clk) disable iff (rst)
    (data_word & ~$past(data_word) & ~$past(ch_load)) == '0);

  // R4: any stretched bit requests an interrupt on the following edge
  p_data_drives_irq_r4: assert property (@(posedge clk) disable iff (rst)
    (data_word != '0) |=> irq);

  // R5: a call load produces the interrupt two edges later
  p_call_raises_irq_r5: assert property (@(posedge clk) disable iff (rst)
    call_load |=> ##1 irq);

  // R8: reset clears the outputs
  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> (data_word == '0 && !irq));

endmodule

bind pulse_irq_frontend pirq_checker #(.NUM_CH(NUM_CH)) u_pirq_chk (
  .clk       (clk),
  .rst       (rst),
  .data_word (data_word),
  .irq       (irq),
  .ch_load   (ch_load),
  .call_load (call_load)
);

// File: tb/tb_pulse_irq_frontend.sv
`timescale 1ns/1ps
module tb_pulse_irq_frontend;

  localparam int NCH = 8;
  localparam int P   = 16;
  localparam int HN  = 1024;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] ev_in = '0;
  logic [NCH-1:0] ch_enable = '1;
  logic           call_req = 1'b0;
  logic [NCH-1:0] data_word;
  logic           irq;

  int checks = 0;
  int failures = 0;
  int t = 1;
  logic [NCH-1:0] hist [HN];
  logic           chist[HN];
  logic [NCH-1:0] last_data;
  logic           last_irq;
  bit             done = 0;

  always #4 clk = ~clk;

  pulse_irq_frontend #(.NUM_CH(NCH), .PULSE_CYCLES(P)) dut (
    .clk(clk), .rst(rst), .ev_in(ev_in), .ch_enable(ch_enable),
    .call_req(call_req), .data_word(data_word), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Load happens at edge m when the masked input drawn for edge m-2 was high
  // and the one for edge m-3 was low; the bit stays set for P edges.
  function automatic logic [NCH-1:0] exp_data(int tt);
    logic [NCH-1:0] r = '0;
    for (int m = tt - P + 1; m <= tt; m++)
      if (m >= 3) r |= hist[(m-2)%HN] & ~hist[(m-3)%HN];
    return r;
  endfunction

  function automatic logic exp_call(int tt);
    logic r = 1'b0;
    for (int m = tt - P + 1; m <= tt; m++)
      if (m >= 3) r |= chist[(m-2)%HN] & ~chist[(m-3)%HN];
    return r;
  endfunction

  function automatic logic exp_irq(int tt);
    if (tt < 2) return 1'b0;
    return (|exp_data(tt-1)) | exp_call(tt-1);
  endfunction

  // Sample the state after edge t, then drive the inputs for edge t+1.
  task automatic step(input logic [NCH-1:0] ev, input logic c);
    @(negedge clk);
    last_data = data_word;
    last_irq  = irq;
    if (rst) begin
      chk(data_word == '0 && irq == 1'b0, "R8 reset state", {data_word, irq}, 0);
    end else begin
      chk(data_word == exp_data(t), "R1/R2/R3/R6 model data", data_word, exp_data(t));
      chk(irq == exp_irq(t), "R4/R5 model irq", irq, exp_irq(t));
    end
    ev_in = ev;
    call_req = c;
    t++;
    hist[t%HN]  = ev & ch_enable;
    chist[t%HN] = c;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, 1'b0);
  endtask

  initial begin
    int cnt;
    int bad;
    int falls;
    logic prev_i;
    logic seen;
    logic [NCH-1:0] ev;
    logic c;
    for (int i = 0; i < HN; i++) begin hist[i] = '0; chist[i] = 1'b0; end
    void'($urandom(32'd20240611));

    idle(4);
    rst = 1'b0;
    idle(3);
    chk(last_data == '0 && last_irq == 1'b0, "R8 after reset", {last_data, last_irq}, 0);

    // R1 latency and R2 length, R9 single pulse while held
    step(8'h04, 0); step(8'h04, 0);
    chk(last_data[2] == 1'b0, "R1 too early edge1", last_data, 0);
    step(8'h04, 0);
    chk(last_data[2] == 1'b0, "R1 too early edge2", last_data, 0);
    step(8'h04, 0);
    chk(last_data[2] == 1'b1, "R1 set on third edge", last_data, 8'h04);
    chk(last_irq == 1'b0, "R4 irq lags data", last_irq, 0);
    step(8'h04, 0);
    chk(last_irq == 1'b1, "R4 irq one clock after data", last_irq, 1);
    cnt = 2;
    while (last_data[2] && cnt < 3*P) begin step(8'h04, 0); if (last_data[2]) cnt++; end
    chk(cnt == P, "R2 pulse length", cnt, P);
    bad = 0;
    for (int i = 0; i < 20; i++) begin step(8'h04, 0); if (last_data != '0) bad++; end
    chk(bad == 0, "R9 held level no repeat", bad, 0);
    idle(P + 4);

    // R3 retrigger: loads six cycles apart
    cnt = 0;
    for (int i = 0; i < 50; i++) begin
      step(((i < 2) || (i >= 6 && i < 8)) ? 8'h20 : 8'h00, 0);
      if (last_data[5]) cnt++;
    end
    chk(cnt == 6 + P, "R3 retrigger length", cnt, 6 + P);
    idle(P + 4);

    // R5 call acknowledge, held high
    cnt = 0; bad = 0;
    for (int i = 0; i < 3*P; i++) begin
      step('0, 1'b1);
      if (last_irq) cnt++;
      if (last_data != '0) bad++;
    end
    chk(cnt == P, "R5 call pulse length", cnt, P);
    chk(bad == 0, "R5 call sets no data", bad, 0);
    idle(P + 4);

    // R6 disabled channel ignored
    ch_enable = 8'hFE;
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      step(((i/2)%2 == 0) ? 8'h01 : 8'h00, 0);
      if (last_data != '0 || last_irq) bad++;
    end
    chk(bad == 0, "R6 masked channel silent", bad, 0);
    idle(6);
    ch_enable = 8'hFF;
    idle(4);

    // R7 fast toggling keeps irq steady
    falls = 0; seen = 1'b0; prev_i = 1'b0;
    for (int i = 0; i < 100; i++) begin
      step(((i%4) < 2) ? 8'h02 : 8'h00, 0);
      if (seen && prev_i && !last_irq) falls++;
      if (last_irq) seen = 1'b1;
      prev_i = last_irq;
    end
    chk(seen && falls == 0, "R7 no irq toggling", falls, 0);
    idle(P + 4);

    // Random phase with two enable patterns
    ev = '0; c = 1'b0;
    for (int ph = 0; ph < 2; ph++) begin
      ch_enable = (ph == 0) ? 8'hFF : 8'h5A;
      idle(4);
      for (int i = 0; i < 1500; i++) begin
        ev = ev ^ NCH'($urandom & $urandom & $urandom);
        if (($urandom % 32) == 0) c = ~c;
        step(ev, c);
      end
      ev = '0; c = 1'b0;
      idle(P + 6);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule